// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM of 256K words by 16 bits. The host presents one single-word request at a time and holds it until a one-cycle ready pulse marks completion. Each request carries a direction bit, an 18-bit word address, 16 bits of write data and a 2-bit lane mask. The controller turns the request into active-low chip-select, write-strobe, output-gate and per-lane byte-enable signals for the RAM. It also drives a separate data-out bus with a drive-enable and captures the RAM's data-in bus during reads.

Every phase of an access is a whole number of clock cycles. Each phase length is worked out at elaboration as the nanosecond limit divided by the clock period, rounded up, with a minimum of one cycle. All memory-side outputs are registered. A write is always closed by the write strobe rising while chip select and the lane enables are still held low. The data drivers are only switched on when the RAM cannot be driving the bus. After reset a power-up wait passes before the first request is taken.

Top module: `sram_ctl`

## Requirements
- R1: After reset, chip select, write strobe and output gate sit high, the data drive-enable is low and ready is low. No request is taken until the power-up wait has elapsed: 10000 cycles with the default 200 us at 20 ns. A request held from reset release therefore completes with ready seen after the 10001st clock edge.
- R2: A read drives chip select and output gate low and keeps the write strobe high. Address and byte enables are held unchanged from the acceptance edge for as long as chip select stays low.
- R3: Read data is captured after at least 45 ns of stable address and 22 ns of output gate low. Lanes whose mask bit is 0 return zero in `rd_data`. With a 20 ns clock, ready for a read is seen after the 6th clock edge counting the acceptance edge.
- R4: A write drives chip select and write strobe low with the output gate high. Byte-enable bit 0 (lane mask bit 0, data bits 7:0) and bit 1 (mask bit 1, bits 15:8) go low only for mask bits that are 1. Only those lanes change in memory. With a 20 ns clock, ready is seen after the 5th edge.
- R5: The write strobe is low for at least 35 ns (2 cycles at 20 ns) and rises while chip select is low and data is still driven. Chip select, the lane enables and the drive-enable release one edge later.
- R6: A request with lane mask 0 issues no strobe at all. It is acknowledged with ready seen after the acceptance edge itself.
- R7: Ready is high for exactly one cycle per completed request.
- R8: The data drive-enable is only high while the output gate is high. It is only high at least 18 ns after the RAM last had its outputs switched on.
- R9: Chip select is high whenever ready is high and between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read data, masked lanes zero |
| mem_addr | output | 18 | RAM address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output gate, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Data toward RAM |
| mem_dq_oe | output | 1 | Drive-enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data from RAM |

## Verification
Random reads, writes and empty-mask requests go to a small address pool plus the two end addresses. Reads therefore return data written earlier with a different lane mask, which separates correct lane merging from whole-word writes. Directed single-lane writes followed by full reads show which lane was touched. Reads with one lane masked show that disabled lanes are zeroed rather than passed through. A read followed directly by a write exposes any bus overlap. Strobe widths and latencies are measured at the memory pins in every access.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [3:0] {
        ST_STARTUP,
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_TURNAROUND
    } ctl_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STB_OFF = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_startup.sv
module sram_ctl_startup #(
    parameter int N = 10000
) (
    input  logic clk,
    input  logic rst,
    output logic done
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CW'(N - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_ctl_lane.sv
module sram_ctl_lane #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              en,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (cap)
            q <= en ? din : '0;
    end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS     = 20,
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int LANE_W     = 8,
    parameter int T_AA_NS    = 45,
    parameter int T_DOE_NS   = 22,
    parameter int T_RC_NS    = 45,
    parameter int T_PWE_NS   = 35,
    parameter int T_AW_NS    = 35,
    parameter int T_SD_NS    = 25,
    parameter int T_WC_NS    = 45,
    parameter int T_HZ_NS    = 18,
    parameter int T_PWRUP_NS = 200000,
    localparam int LANES     = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // Cycles with output gate low before capture; address has one extra cycle.
    localparam int N_RDW = imax(imax(ns2cyc(T_AA_NS, CLK_NS) - 1, ns2cyc(T_DOE_NS, CLK_NS)),
                                imax(ns2cyc(T_RC_NS, CLK_NS) - 1, 1));
    // Cycles of write strobe low; address/data/enables lead it by one cycle.
    localparam int N_PW  = imax(imax(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS) - 1),
                                imax(ns2cyc(T_SD_NS, CLK_NS) - 1, ns2cyc(T_WC_NS, CLK_NS) - 2));
    localparam int N_HZ    = ns2cyc(T_HZ_NS, CLK_NS);
    localparam int N_START = ns2cyc(T_PWRUP_NS, CLK_NS);
    localparam int T_MAX   = imax(imax(N_RDW, N_PW), N_HZ);
    localparam int TW      = (T_MAX > 1) ? $clog2(T_MAX) : 1;

    ctl_state_e        state;
    strobe_t           stb;
    logic              t_load;
    logic [TW-1:0]     t_val;
    logic              t_done;
    logic              st_done;
    logic              cap;

    assign mem_ce_n  = stb.ce_n;
    assign mem_we_n  = stb.we_n;
    assign mem_oe_n  = stb.oe_n;
    assign mem_dq_oe = stb.dq_oe;

    sram_ctl_startup #(.N(N_START)) u_startup (
        .clk  (clk),
        .rst  (rst),
        .done (st_done)
    );

    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        case (state)
            ST_RD_SETUP: begin t_load = 1'b1; t_val = TW'(N_RDW - 1); end
            ST_WR_SETUP: begin t_load = 1'b1; t_val = TW'(N_PW - 1);  end
            ST_RD_DONE:  begin t_load = 1'b1; t_val = TW'(N_HZ - 1);  end
            default: ;
        endcase
    end

    sram_ctl_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    assign cap = (state == ST_RD_WAIT) && t_done;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_ctl_lane #(.LANE_W(LANE_W)) u_lane (
            .clk (clk),
            .rst (rst),
            .cap (cap),
            .en  (~mem_be_n[g]),
            .din (mem_dq_in[g*LANE_W +: LANE_W]),
            .q   (rd_data[g*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_STARTUP;
            stb        <= STB_OFF;
            mem_addr   <= '0;
            mem_be_n   <= '1;
            mem_dq_out <= '0;
            req_ready  <= 1'b0;
        end else begin
            req_ready <= 1'b0;
            case (state)
                ST_STARTUP: begin
                    if (st_done)
                        state <= ST_IDLE;
                end
                ST_IDLE: begin
                    stb <= STB_OFF;
                    if (req_valid) begin
                        if (req_mask == '0) begin
                            req_ready <= 1'b1;
                        end else begin
                            mem_addr <= req_addr;
                            mem_be_n <= ~req_mask;
                            stb.ce_n <= 1'b0;
                            if (req_write) begin
                                mem_dq_out <= req_wdata;
                                stb.dq_oe  <= 1'b1;
                                state      <= ST_WR_SETUP;
                            end else begin
                                state <= ST_RD_SETUP;
                            end
                        end
                    end
                end
                ST_RD_SETUP: begin
                    stb.oe_n <= 1'b0;
                    state    <= ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    if (t_done) begin
                        stb      <= STB_OFF;
                        mem_be_n <= '1;
                        state    <= ST_RD_DONE;
                    end
                end
                ST_RD_DONE: begin
                    state <= ST_TURNAROUND;
                end
                ST_TURNAROUND: begin
                    if (t_done) begin
                        req_ready <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                ST_WR_SETUP: begin
                    stb.we_n <= 1'b0;
                    state    <= ST_WR_PULSE;
                end
                ST_WR_PULSE: begin
                    if (t_done) begin
                        stb.we_n <= 1'b1;
                        state    <= ST_WR_RECOVER;
                    end
                end
                ST_WR_RECOVER: begin
                    stb       <= STB_OFF;
                    mem_be_n  <= '1;
                    req_ready <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: begin
                    stb   <= STB_OFF;
                    state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W  = 18,
    parameter int LANES   = 2,
    parameter int N_START = 10000
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_be_n,
    input logic              mem_dq_oe
);
    localparam int CW = $clog2(N_START + 1);

    logic [CW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != CW'(N_START))
            since_rst <= since_rst + 1'b1;
    end

    AST_STARTUP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (since_rst < CW'(N_START)) |-> (mem_ce_n && !req_ready)); // R1

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n))); // R2

    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_we_n && !mem_oe_n)); // R4

    AST_WE_RISE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && (mem_be_n != '1))); // R5

    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe)); // R5

    AST_NO_EMPTY_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> (mem_be_n != '1)); // R6

    AST_READY_ONE: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready); // R7

    AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n); // R8

    AST_READY_CE_HIGH: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_ce_n); // R9
endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W  (ADDR_W),
    .LANES   (LANES),
    .N_START (N_START)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb;
    localparam int RD_EDGES = 6;
    localparam int WR_EDGES = 5;
    localparam int NOP_EDGES = 1;
    localparam int START_EDGES = 10001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'h5A5A;

    int checks = 0;
    int fails = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;
    time we_fall_t = 0;
    time last_drive_t = 0;
    logic [15:0] mem_arr [int];
    logic [15:0] ref_arr [int];

    always #10 clk = ~clk;

    sram_ctl u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [17:0] a, input logic [1:0] m);
        logic [15:0] w;
        w = ref_arr.exists(int'(a)) ? ref_arr[int'(a)] : 16'h0000;
        if (!m[0]) w[7:0] = 8'h00;
        if (!m[1]) w[15:8] = 8'h00;
        return w;
    endfunction

    function automatic logic [15:0] merge_write(input logic [15:0] old, input logic [15:0] d, input logic [1:0] m);
        logic [15:0] w;
        w = old;
        if (m[0]) w[7:0] = d[7:0];
        if (m[1]) w[15:8] = d[15:8];
        return w;
    endfunction

    // RAM model: writes at the rising write strobe, reads driven between edges.
    always @(negedge mem_we_n) if (model_on) we_fall_t = $time;

    always @(posedge mem_we_n) begin
        if (model_on && !mem_ce_n) begin
            logic [15:0] w;
            check(($time - we_fall_t) >= 35, "R5 strobe width", 32'($time - we_fall_t), 35);
            check(mem_dq_oe, "R5 data held at strobe rise", {31'd0, mem_dq_oe}, 1);
            w = mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : 16'h0000;
            if (!mem_be_n[0]) w[7:0] = mem_dq_out[7:0];
            if (!mem_be_n[1]) w[15:8] = mem_dq_out[15:8];
            mem_arr[int'(mem_addr)] = w;
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
                logic [15:0] v;
                v = mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : 16'h0000;
                if (mem_be_n[0]) v[7:0] = 8'hA5;
                if (mem_be_n[1]) v[15:8] = 8'hA5;
                mem_dq_in = v;
                last_drive_t = $time;
            end else begin
                mem_dq_in = 16'h5A5A;
            end
            if (mem_dq_oe)
                check(($time - last_drive_t) >= 38, "R8 drive after release",
                      32'($time - last_drive_t), 38);
        end
    end

    task automatic do_access(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        int edges = 0;
        int ce_cyc = 0;
        int we_cyc = 0;
        int oe_cyc = 0;
        bit bad_addr = 0;
        bit bad_dir = 0;
        bit timeout = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        forever begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (!mem_ce_n) begin
                ce_cyc++;
                if (mem_addr != a || mem_be_n != ~m) bad_addr = 1;
                if (wr && !mem_oe_n) bad_dir = 1;
                if (!wr && !mem_we_n) bad_dir = 1;
            end
            if (!mem_we_n) we_cyc++;
            if (!mem_oe_n) oe_cyc++;
            if (req_ready) break;
            if (edges > 40) begin timeout = 1; break; end
        end
        req_valid = 1'b0;
        check(!timeout, "R7 ready arrives", 32'(edges), 0);
        if (m == 2'b00) begin
            check(edges == NOP_EDGES, "R6 empty-mask latency", 32'(edges), NOP_EDGES);
            check(ce_cyc == 0 && we_cyc == 0 && oe_cyc == 0, "R6 no strobe", 32'(ce_cyc + we_cyc + oe_cyc), 0);
        end else if (wr) begin
            check(edges == WR_EDGES, "R4 write latency", 32'(edges), WR_EDGES);
            check(!bad_dir && oe_cyc == 0, "R4 write strobes", {31'd0, bad_dir}, 0);
            check(we_cyc == 2, "R5 strobe cycles", 32'(we_cyc), 2);
            check(!bad_addr, "R4 address and lanes", {14'd0, mem_addr}, {14'd0, a});
            ref_arr[int'(a)] = merge_write(ref_arr.exists(int'(a)) ? ref_arr[int'(a)] : 16'h0000, d, m);
        end else begin
            check(edges == RD_EDGES, "R3 read latency", 32'(edges), RD_EDGES);
            check(!bad_dir && oe_cyc > 0 && we_cyc == 0, "R2 read strobes", {31'd0, bad_dir}, 0);
            check(!bad_addr, "R2 address held", {14'd0, mem_addr}, {14'd0, a});
            check(rd_data == exp_read(a, m), "R3 read data", {16'd0, rd_data}, {16'd0, exp_read(a, m)});
        end
        check(mem_ce_n == 1'b1, "R9 select high at ready", {31'd0, mem_ce_n}, 1);
        @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b0, "R7 single-cycle ready", {31'd0, req_ready}, 0);
        check(mem_ce_n == 1'b1 && mem_dq_oe == 1'b0, "R9 idle between accesses", {30'd0, mem_ce_n, mem_dq_oe}, 2);
    endtask

    function automatic logic [17:0] pick_addr();
        case ($urandom % 6)
            0: return 18'h00000;
            1: return 18'h3FFFF;
            default: return 18'h01230 + 18'($urandom % 8);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd19937));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready, "R1 reset state",
              {27'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11100);
        rst = 1'b0;
        model_on = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_mask = 2'b00; req_addr = '0;
        begin
            int edges = 0;
            bit early_sel = 0;
            forever begin
                @(posedge clk);
                edges++;
                @(negedge clk);
                if (!mem_ce_n) early_sel = 1;
                if (req_ready || edges > START_EDGES + 20) break;
            end
            req_valid = 1'b0;
            check(edges == START_EDGES, "R1 power-up wait", 32'(edges), START_EDGES);
            check(!early_sel, "R1 no select during wait", {31'd0, early_sel}, 0);
        end
        @(negedge clk);

        // Directed corners
        do_access(1, 18'h00000, 16'hFFFF, 2'b11);
        do_access(1, 18'h3FFFF, 16'h0000, 2'b11);
        do_access(0, 18'h00000, 16'h0000, 2'b11);
        do_access(1, 18'h3FFFF, 16'hC3C3, 2'b11);
        do_access(0, 18'h3FFFF, 16'h0000, 2'b11);
        do_access(1, 18'h00000, 16'h1234, 2'b01);   // R4 low lane only
        do_access(0, 18'h00000, 16'h0000, 2'b11);
        do_access(1, 18'h00000, 16'hABCD, 2'b10);   // R4 high lane only
        do_access(0, 18'h00000, 16'h0000, 2'b11);
        do_access(0, 18'h00000, 16'h0000, 2'b01);   // R3 high lane masked
        do_access(0, 18'h00000, 16'h0000, 2'b10);   // R3 low lane masked
        do_access(1, 18'h00000, 16'h5555, 2'b00);   // R6 empty mask, no change
        do_access(0, 18'h00000, 16'h0000, 2'b11);
        do_access(0, 18'h3FFFF, 16'h0000, 2'b11);   // R8 read then write
        do_access(1, 18'h3FFFF, 16'h7E81, 2'b11);

        for (int i = 0; i < 300; i++)
            do_access(1'($urandom % 2), pick_addr(), 16'($urandom), 2'($urandom % 4));

        for (int i = 0; i < 8; i++)
            do_access(0, 18'h01230 + 18'(i), 16'h0000, 2'b11);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule